// File: doc/BRIEF.md
# Tone Code Serial Readout

This block hands a decoded four-bit tone code to an external controller over a single serial pin. The controller clocks the code out by toggling an acknowledge input four times. The block takes a copy of the code on the first rising edge of acknowledge and presents one bit per pulse, least-significant bit first. At all other times the same pin carries the energy-present indication, so the controller can follow the cadence of call-progress tones on it.

A code becomes readable only after the producer marks it valid while acknowledge is low. Acknowledge is asynchronous, so it passes through a two-stage synchroniser before edge detection. A power-down request forces the pin low. The request is taken only while acknowledge is low. Taking it mid-readout abandons the readout.

Top module: `tone_serial_readout`

## Requirements
- R1: Outside a readout window and out of power-down, `sd_out` equals the value `energy_in` had at the previous rising clock edge.
- R2: The code is captured from `code_in` on the first synchronised rising edge of `ack_in` after `code_valid` was seen high with acknowledge low. Changes to `code_in` after that edge do not alter the bits sent.
- R3: The bits go out least-significant first, with bit `i` (bit 0 = LSB of `code_in`) on the pin after the (i+1)-th rising edge. `sd_out` changes on the third rising clock edge after the edge that first samples the new `ack_in` level.
- R4: A readout window runs from the first acknowledge rise to the fall of the fourth pulse. Inside it, `energy_in` has no effect on `sd_out`. After the fourth fall, `sd_out` carries the energy indication again.
- R5: While power-down is in effect, `sd_out` is 0. It goes low on the clock edge after the request is accepted.
- R6: A power-down request is accepted only while the synchronised acknowledge is low. A request made while acknowledge is high takes effect once acknowledge has been low through the synchroniser.
- R7: Power-down during a readout clears the pulse count and discards the pending code. After release, `sd_out` shows `energy_in`, and further pulses are ignored until a new code is validated.
- R8: Acknowledge pulses beyond the fourth, or pulses with no validated code, leave `sd_out` following `energy_in`.
- R9: A synchronous active-high reset drives `sd_out` to 0 and leaves no code armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ack_in | input | 1 | Asynchronous acknowledge/shift clock, idles low |
| code_in | input | 4 | Decoded tone code |
| code_valid | input | 1 | High when `code_in` holds a newly validated code |
| energy_in | input | 1 | Energy-present indication |
| pwrdn_req | input | 1 | Power-down request |
| sd_out | output | 1 | Serial data or energy indication |

## Verification
An `energy_in` change shows on `sd_out` one edge after it is sampled. An `ack_in` change shows on `sd_out` three edges after the edge that first samples it: two synchroniser stages, the sequencer register, then the output register. An accepted power-down shows one edge later. The bench holds a behavioural model that keeps an acknowledge history queue and applies exactly these delays. The model is compared with `sd_out` at every falling edge. Directed readouts hold each acknowledge level for five cycles and sample the pin only after the three-edge delay has passed.

// File: rtl/tone_serial_readout_pkg.sv
package tone_serial_readout_pkg;
  localparam int CODE_W_DEF  = 4;
  localparam int SYNC_N_DEF  = 2;

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } ack_evt_t;
endpackage

// File: rtl/ack_edge_sync.sv
module ack_edge_sync
  import tone_serial_readout_pkg::*;
#(
  parameter int SYNC_N = SYNC_N_DEF
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     ack_async,
  output ack_evt_t evt
);
  logic [SYNC_N-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain[0] <= ack_async;
      for (int i = 1; i < SYNC_N; i++) chain[i] <= chain[i-1];
      prev <= chain[SYNC_N-1];
    end
  end

  always_comb begin
    evt.lvl  = chain[SYNC_N-1];
    evt.rise = chain[SYNC_N-1] & ~prev;
    evt.fall = ~chain[SYNC_N-1] & prev;
  end
endmodule

// File: rtl/pwrdn_gate.sv
module pwrdn_gate (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic ack_lvl,
  output logic pd_q
);
  // enter only while acknowledge is low; leave as soon as the request drops
  always_ff @(posedge clk) begin
    if (rst) pd_q <= 1'b0;
    else     pd_q <= req & (pd_q | ~ack_lvl);
  end
endmodule

// File: rtl/readout_seq.sv
module readout_seq
  import tone_serial_readout_pkg::*;
#(
  parameter int CODE_W = CODE_W_DEF,
  localparam int CNT_W = $clog2(CODE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  ack_evt_t          evt,
  input  logic              pd_q,
  input  logic              code_valid,
  input  logic [CODE_W-1:0] code_in,
  output logic              window,
  output logic              armed,
  output logic [CNT_W-1:0]  cnt,
  output logic              cur_bit
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_W);

  logic [CODE_W-1:0] shreg;
  logic              start;

  assign start   = evt.rise & armed & ~window;
  assign cur_bit = shreg[0];

  always_ff @(posedge clk) begin
    if (rst || pd_q) begin
      window <= 1'b0;
      cnt    <= '0;
      armed  <= 1'b0;
      shreg  <= '0;
    end else begin
      if (start) begin
        shreg  <= code_in;
        cnt    <= CNT_W'(1);
        window <= 1'b1;
      end else if (evt.rise && window && cnt != LAST) begin
        shreg <= {1'b0, shreg[CODE_W-1:1]};
        cnt   <= cnt + CNT_W'(1);
      end else if (evt.fall && window && cnt == LAST) begin
        window <= 1'b0;
        cnt    <= '0;
      end

      if (start) armed <= 1'b0;
      else if (code_valid && !evt.lvl && !window) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/tone_serial_readout.sv
module tone_serial_readout
  import tone_serial_readout_pkg::*;
#(
  parameter int CODE_W = CODE_W_DEF,
  parameter int SYNC_N = SYNC_N_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack_in,
  input  logic [CODE_W-1:0] code_in,
  input  logic              code_valid,
  input  logic              energy_in,
  input  logic              pwrdn_req,
  output logic              sd_out
);
  localparam int CNT_W = $clog2(CODE_W + 1);

  ack_evt_t         evt;
  logic             pd_q;
  logic             window;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic             cur_bit;

  ack_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .ack_async(ack_in), .evt(evt)
  );

  pwrdn_gate u_pd (
    .clk(clk), .rst(rst), .req(pwrdn_req), .ack_lvl(evt.lvl), .pd_q(pd_q)
  );

  readout_seq #(.CODE_W(CODE_W)) u_seq (
    .clk(clk), .rst(rst), .evt(evt), .pd_q(pd_q), .code_valid(code_valid),
    .code_in(code_in), .window(window), .armed(armed), .cnt(cnt),
    .cur_bit(cur_bit)
  );

  always_ff @(posedge clk) begin
    if (rst)         sd_out <= 1'b0;
    else if (pd_q)   sd_out <= 1'b0;
    else if (window) sd_out <= cur_bit;
    else             sd_out <= energy_in;
  end
endmodule

// File: rtl/tone_serial_readout_chk.sv
module tone_serial_readout_chk #(
  parameter int CNT_W  = 3,
  parameter int CODE_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             energy_in,
  input logic             sd_out,
  input logic             pd_q,
  input logic             ack_lvl,
  input logic             window,
  input logic             armed,
  input logic [CNT_W-1:0] cnt
);
  // R1
  energy_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!pd_q && !window) |=> (sd_out == $past(energy_in)));
  // R5
  pd_low_chk: assert property (@(posedge clk) disable iff (rst)
    pd_q |=> !sd_out);
  // R6
  pd_ack_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_q) |-> !$past(ack_lvl));
  // R7
  pd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    pd_q |=> (cnt == '0 && !window && !armed));
  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(CODE_W));
  // R8
  no_start_unarmed_chk: assert property (@(posedge clk) disable iff (rst)
    (!armed && !window) |=> !window);
endmodule

bind tone_serial_readout tone_serial_readout_chk #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .energy_in(energy_in), .sd_out(sd_out), .pd_q(pd_q),
  .ack_lvl(evt.lvl), .window(window), .armed(armed), .cnt(cnt)
);

// File: tb/tb_tone_serial_readout.sv
module tb_tone_serial_readout;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ack_in = 1'b0;
  logic [W-1:0] code_in = '0;
  logic code_valid = 1'b0;
  logic energy_in = 1'b0;
  logic pwrdn_req = 1'b0;
  logic sd_out;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  tone_serial_readout dut (
    .clk(clk), .rst(rst), .ack_in(ack_in), .code_in(code_in),
    .code_valid(code_valid), .energy_in(energy_in), .pwrdn_req(pwrdn_req),
    .sd_out(sd_out)
  );

  // behavioural reference
  int hist[$];
  bit m_pd, m_win, m_armed, exp_sd;
  int m_idx;
  logic [W-1:0] m_code;

  always @(posedge clk) begin
    if (rst) begin
      hist = '{0, 0, 0, 0};
      m_pd = 0; m_win = 0; m_armed = 0; m_idx = 0; m_code = '0; exp_sd = 0;
    end else begin
      bit r, f, lvl, o_pd, o_win, go;
      exp_sd = m_pd ? 1'b0 : (m_win ? m_code[m_idx-1] : energy_in);
      hist.push_front(int'(ack_in));
      void'(hist.pop_back());
      lvl = (hist[2] != 0);
      r = lvl && hist[3] == 0;
      f = !lvl && hist[3] != 0;
      o_pd = m_pd; o_win = m_win; go = 0;
      if (o_pd) begin
        m_win = 0; m_idx = 0; m_armed = 0;
      end else begin
        if (r && m_armed && !o_win) begin
          m_code = code_in; m_idx = 1; m_win = 1; go = 1;
        end else if (r && o_win && m_idx < W) m_idx++;
        else if (f && o_win && m_idx == W) begin
          m_win = 0; m_idx = 0;
        end
        if (go) m_armed = 0;
        else if (code_valid && !lvl && !o_win) m_armed = 1;
      end
      m_pd = pwrdn_req && (o_pd || !lvl);
    end
  end

  task automatic chk(string req, bit act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: sd_out=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst) chk(cur_req, sd_out, exp_sd);

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic validate(logic [W-1:0] c);
    code_in = c; code_valid = 1'b1; wait_n(1); code_valid = 1'b0; wait_n(1);
  endtask

  task automatic pulse(output bit b);
    ack_in = 1'b1; wait_n(5); b = sd_out; ack_in = 1'b0; wait_n(5);
  endtask

  task automatic read_code(output logic [W-1:0] got);
    for (int i = 0; i < W; i++) begin
      bit b;
      pulse(b); got[i] = b;
    end
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: expired expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] got;
    bit b;
    wait_n(3);
    chk("R9", sd_out, 1'b0);
    rst = 1'b0;
    // R8: pulses after reset with no validated code are ignored
    cur_req = "R8"; energy_in = 1'b1; pulse(b); chk("R8", b, 1'b1);
    // R1: energy passthrough
    cur_req = "R1"; energy_in = 1'b0; wait_n(2); chk("R1", sd_out, 1'b0);
    energy_in = 1'b1; wait_n(1); chk("R1", sd_out, 1'b1);
    // R2/R3: code 0xA, code_in altered after first pulse
    cur_req = "R3"; validate(4'hA); code_in = 4'h5;
    pulse(b); got[0] = b; code_in = 4'h3;
    for (int i = 1; i < W; i++) begin
      bit bb;
      pulse(bb); got[i] = bb;
    end
    chk("R2", got == 4'h5, 1'b1);
    // R4: back to energy after fourth fall
    cur_req = "R4"; energy_in = 1'b0; wait_n(2); chk("R4", sd_out, 1'b0);
    // R3 second pattern with energy toggling inside window (R4)
    validate(4'h6); energy_in = 1'b1; read_code(got);
    chk("R3", got == 4'h6, 1'b1);
    validate(4'h1); energy_in = 1'b1;
    pulse(b); chk("R3", b, 1'b1);
    energy_in = 1'b0; pulse(b); chk("R4", b, 1'b0);
    energy_in = 1'b1; pulse(b); chk("R4", b, 1'b0);
    energy_in = 1'b0; pulse(b); chk("R4", b, 1'b0);
    // R8: fifth pulse ignored
    cur_req = "R8"; energy_in = 1'b1; pulse(b); chk("R8", b, 1'b1);
    validate(4'hF); read_code(got); chk("R3", got == 4'hF, 1'b1);
    // R5: power-down with ack low
    cur_req = "R5"; energy_in = 1'b1; pwrdn_req = 1'b1; wait_n(3);
    chk("R5", sd_out, 1'b0);
    pwrdn_req = 1'b0; wait_n(3); chk("R5", sd_out, 1'b1);
    // R6: request while ack high deferred
    cur_req = "R6"; ack_in = 1'b1; wait_n(5); pwrdn_req = 1'b1; wait_n(4);
    chk("R6", sd_out, 1'b1);
    ack_in = 1'b0; wait_n(5); chk("R6", sd_out, 1'b0);
    pwrdn_req = 1'b0; wait_n(3);
    // R7: power-down mid readout
    cur_req = "R7"; validate(4'h0); energy_in = 1'b1;
    pulse(b); chk("R7", b, 1'b0);
    pulse(b);
    pwrdn_req = 1'b1; wait_n(3); chk("R7", sd_out, 1'b0);
    pwrdn_req = 1'b0; wait_n(3); chk("R7", sd_out, 1'b1);
    pulse(b); chk("R7", b, 1'b1);
    validate(4'h9); read_code(got); chk("R7", got == 4'h9, 1'b1);
    // R9: reset mid readout
    cur_req = "R9"; validate(4'h0); pulse(b);
    rst = 1'b1; wait_n(2); chk("R9", sd_out, 1'b0);
    rst = 1'b0; energy_in = 1'b1; pulse(b); chk("R9", b, 1'b1);
    wait_n(5);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule